// File: doc/BRIEF.md
# Memory Array Integrity Sweeper

This block walks a memory array across an inclusive address window chosen by software. It reads one word at a time through a simple synchronous read port and passes each 39-bit codeword through a SECDED decoder covering 32 data bits. The decoded data is folded into a 32-bit multiple-input signature register. The signature depends on both the stored content and the addresses actually decoded, so one value summarises the whole array. The block never judges the signature. Software reads the final value and compares it against its own expected constant.

Corrected single-bit events and uncorrectable double-bit events raise sticky status flags. The address of the most recent event can be latched on request. Two optional breakpoints freeze the sweep on either kind of event. The sweep picks up at the following address once software clears the flag that caused the stop. An abort returns the block to idle at any moment and leaves the partial signature readable.

Top module: `array_integrity_checker`

## Requirements
- R1: After reset the block is idle: `busy_o`, `done_o`, `halted_o`, `sbc_o` and `err_o` are low. A `start_i` pulse while idle or finished does the following: latches the window and options, clears `sbc_o`, `err_o` and `evt_addr_o`, loads the signature with all ones and raises `busy_o`. It then requests every address from `lo_addr_i` to `hi_addr_i` (with `lo_addr_i <= hi_addr_i`) exactly once, in ascending order, with at most one `mem_req_o` cycle in any two consecutive cycles. `mem_rdata_i` must hold the addressed codeword in the cycle after the request.
- R2: For each word read, the signature S becomes ({S[30:0],0} XOR (S[31] ? 32'h0040_0007 : 0)) XOR D, where D is the decoded data word. This corresponds to the polynomial x^32+x^22+x^2+x+1. A single-word sweep of data 0 therefore ends with 32'hFFBF_FFF9.
- R3: Codeword layout: bit 0 holds even parity over all 39 bits. Bits 1 to 38 are Hamming positions. Check bits sit at positions 1, 2, 4, 8, 16 and 32. Data bits 0 to 31 fill the remaining positions in ascending order. A single flipped bit, including bit 0, is corrected, so the signature equals the one over clean content.
- R4: A corrected single-bit event sets `sbc_o`. The flag stays set until a `clr_sbc_i` pulse or the next start. A set in the same cycle wins over a clear.
- R5: A double-bit event (syndrome nonzero with even overall parity, or odd parity with a syndrome above 38) sets `err_o`. The uncorrected data bits of that word are folded into the signature.
- R6: When capture is enabled at start, `evt_addr_o` takes the address of each single- or double-bit event. With capture disabled it stays 0 for the whole sweep.
- R7: With the SBC breakpoint enabled, a corrected word halts the sweep after it has been folded in. `halted_o` goes high and no further reads are issued.
- R8: With the error breakpoint enabled, a double-bit word halts the sweep in the same way. A corrected word then does not halt.
- R9: A halted sweep resumes at the next address only after the flag that caused the halt has been cleared. Clearing the other flag leaves it halted.
- R10: After the last word, `done_o` rises and `busy_o` falls. The signature and event address then stay unchanged until the next start.
- R11: `abort_i` returns the block to idle in the next cycle from any state, with `busy_o` and `done_o` low. The partial signature is kept unchanged. Abort wins over a start in the same cycle.
- R12: A `start_i` pulse while busy is ignored: the window, options and signature of the running sweep are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a sweep (pulse) |
| abort_i | input | 1 | Stop the sweep and return to idle (pulse) |
| lo_addr_i | input | AW | First address of the window |
| hi_addr_i | input | AW | Last address of the window |
| halt_on_sbc_i | input | 1 | Breakpoint on corrected single-bit events |
| halt_on_err_i | input | 1 | Breakpoint on double-bit events |
| capture_en_i | input | 1 | Latch event addresses |
| clr_sbc_i | input | 1 | Clear the single-bit flag (pulse) |
| clr_err_i | input | 1 | Clear the double-bit flag (pulse) |
| mem_req_o | output | 1 | Read request to the array |
| mem_addr_o | output | AW | Read address |
| mem_rdata_i | input | 39 | Codeword returned one cycle after the request |
| busy_o | output | 1 | Sweep in progress (including halted) |
| done_o | output | 1 | Sweep finished |
| halted_o | output | 1 | Sweep stopped at a breakpoint |
| sbc_o | output | 1 | Sticky corrected-event flag |
| err_o | output | 1 | Sticky double-bit flag |
| evt_addr_o | output | AW | Address of the last captured event |
| sig_o | output | 32 | Signature register |

## Verification
The hardest case to reach is a halted sweep waiting on the one flag that caused it while the other flag is also set. For that case the bench plants a corrected word before a double-bit word in the same window and breaks only on the double-bit event. It then clears the single-bit flag and confirms that the sweep stays frozen and issues no reads. Only then does it clear the error flag and let the sweep finish. The final signature must match a model that folds the raw data of the broken word and the corrected data of the other word.

// File: rtl/aic_pkg.sv
package aic_pkg;

    localparam int DATA_W  = 32;
    localparam int HAM_TOP = 38;
    localparam int CW_W    = HAM_TOP + 1;
    localparam int SYN_W   = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_UPDATE,
        ST_BREAK,
        ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        MISR_HOLD,
        MISR_SEED,
        MISR_STEP
    } misr_op_e;

    function automatic logic is_pow2(int p);
        return (p & (p - 1)) == 0;
    endfunction

    // Gather the data bits from the non-check Hamming positions.
    function automatic logic [DATA_W-1:0] pick_data(logic [CW_W-1:0] cw);
        logic [DATA_W-1:0] d;
        int k;
        d = '0;
        k = 0;
        for (int p = 1; p <= HAM_TOP; p++) begin
            if (!is_pow2(p)) begin
                d[k] = cw[p];
                k++;
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/aic_secded_dec.sv
module aic_secded_dec
    import aic_pkg::*;
(
    input  logic [CW_W-1:0]   cw_i,
    output logic [DATA_W-1:0] data_o,
    output logic              single_o,
    output logic              double_o
);

    logic [SYN_W-1:0] syn;
    logic             par;
    logic [CW_W-1:0]  fixed;

    always_comb begin
        syn = '0;
        for (int p = 1; p <= HAM_TOP; p++) begin
            if (cw_i[p]) syn = syn ^ SYN_W'(p);
        end
        par      = ^cw_i;
        fixed    = cw_i;
        single_o = 1'b0;
        double_o = 1'b0;
        if (par) begin
            if (syn == '0) begin
                single_o = 1'b1;
            end else if (int'(syn) <= HAM_TOP) begin
                single_o   = 1'b1;
                fixed[syn] = ~cw_i[syn];
            end else begin
                double_o = 1'b1;
            end
        end else if (syn != '0) begin
            double_o = 1'b1;
        end
        data_o = double_o ? pick_data(cw_i) : pick_data(fixed);
    end

endmodule

// File: rtl/aic_misr.sv
module aic_misr
    import aic_pkg::*;
#(
    parameter int          W    = 32,
    parameter logic [W-1:0] TAPS = 32'h0040_0007
) (
    input  logic         clk,
    input  logic         rst_n,
    input  misr_op_e     op_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] sig_o
);

    logic [W-1:0] sig_d, sig_q;

    always_comb begin
        sig_d = sig_q;
        unique case (op_i)
            MISR_SEED: sig_d = '1;
            MISR_STEP: sig_d = ({sig_q[W-2:0], 1'b0} ^ (sig_q[W-1] ? TAPS : '0)) ^ data_i;
            default:   sig_d = sig_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= '0;
        else        sig_q <= sig_d;
    end

    assign sig_o = sig_q;

endmodule

// File: rtl/aic_seq.sv
module aic_seq
    import aic_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          abort_i,
    input  logic [AW-1:0] lo_addr_i,
    input  logic [AW-1:0] hi_addr_i,
    input  logic          halt_on_sbc_i,
    input  logic          halt_on_err_i,
    input  logic          capture_en_i,
    input  logic          clr_sbc_i,
    input  logic          clr_err_i,
    input  logic          ev_single_i,
    input  logic          ev_double_i,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    output misr_op_e      misr_op_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          halted_o,
    output logic          sbc_o,
    output logic          err_o,
    output logic [AW-1:0] evt_addr_o
);

    typedef struct packed {
        seq_state_e    st;
        logic [AW-1:0] addr;
        logic [AW-1:0] last;
        logic          brk_sbc;
        logic          brk_err;
        logic          cap_en;
        logic          sbc;
        logic          err;
        logic [AW-1:0] evt;
        logic          cause_err;
    } regs_t;

    regs_t    r_d, r_q;
    misr_op_e op_d;
    logic     wait_done;

    always_comb begin
        r_d  = r_q;
        op_d = MISR_HOLD;
        wait_done = r_q.cause_err ? !r_q.err : !r_q.sbc;

        if (clr_sbc_i) r_d.sbc = 1'b0;
        if (clr_err_i) r_d.err = 1'b0;

        unique case (r_q.st)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    r_d.st      = ST_READ;
                    r_d.addr    = lo_addr_i;
                    r_d.last    = hi_addr_i;
                    r_d.brk_sbc = halt_on_sbc_i;
                    r_d.brk_err = halt_on_err_i;
                    r_d.cap_en  = capture_en_i;
                    r_d.sbc     = 1'b0;
                    r_d.err     = 1'b0;
                    r_d.evt     = '0;
                    op_d        = MISR_SEED;
                end
            end
            ST_READ: begin
                r_d.st = ST_UPDATE;
            end
            ST_UPDATE: begin
                op_d = MISR_STEP;
                if (ev_single_i) r_d.sbc = 1'b1;
                if (ev_double_i) r_d.err = 1'b1;
                if ((ev_single_i || ev_double_i) && r_q.cap_en) r_d.evt = r_q.addr;
                if (ev_single_i && r_q.brk_sbc) begin
                    r_d.st        = ST_BREAK;
                    r_d.cause_err = 1'b0;
                end else if (ev_double_i && r_q.brk_err) begin
                    r_d.st        = ST_BREAK;
                    r_d.cause_err = 1'b1;
                end else if (r_q.addr == r_q.last) begin
                    r_d.st = ST_DONE;
                end else begin
                    r_d.addr = r_q.addr + 1'b1;
                    r_d.st   = ST_READ;
                end
            end
            ST_BREAK: begin
                if (wait_done) begin
                    if (r_q.addr == r_q.last) begin
                        r_d.st = ST_DONE;
                    end else begin
                        r_d.addr = r_q.addr + 1'b1;
                        r_d.st   = ST_READ;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        if (abort_i) begin
            r_d.st = ST_IDLE;
            op_d   = MISR_HOLD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign misr_op_o  = op_d;
    assign mem_req_o  = (r_q.st == ST_READ);
    assign mem_addr_o = r_q.addr;
    assign busy_o     = (r_q.st == ST_READ) || (r_q.st == ST_UPDATE) || (r_q.st == ST_BREAK);
    assign done_o     = (r_q.st == ST_DONE);
    assign halted_o   = (r_q.st == ST_BREAK);
    assign sbc_o      = r_q.sbc;
    assign err_o      = r_q.err;
    assign evt_addr_o = r_q.evt;

endmodule

// File: rtl/array_integrity_checker.sv
module array_integrity_checker
    import aic_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic [AW-1:0]     lo_addr_i,
    input  logic [AW-1:0]     hi_addr_i,
    input  logic              halt_on_sbc_i,
    input  logic              halt_on_err_i,
    input  logic              capture_en_i,
    input  logic              clr_sbc_i,
    input  logic              clr_err_i,
    output logic              mem_req_o,
    output logic [AW-1:0]     mem_addr_o,
    input  logic [CW_W-1:0]   mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              halted_o,
    output logic              sbc_o,
    output logic              err_o,
    output logic [AW-1:0]     evt_addr_o,
    output logic [DATA_W-1:0] sig_o
);

    logic [DATA_W-1:0] dec_data;
    logic              dec_single;
    logic              dec_double;
    misr_op_e          misr_op;

    aic_secded_dec u_dec (
        .cw_i     (mem_rdata_i),
        .data_o   (dec_data),
        .single_o (dec_single),
        .double_o (dec_double)
    );

    aic_seq #(.AW(AW)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .abort_i       (abort_i),
        .lo_addr_i     (lo_addr_i),
        .hi_addr_i     (hi_addr_i),
        .halt_on_sbc_i (halt_on_sbc_i),
        .halt_on_err_i (halt_on_err_i),
        .capture_en_i  (capture_en_i),
        .clr_sbc_i     (clr_sbc_i),
        .clr_err_i     (clr_err_i),
        .ev_single_i   (dec_single),
        .ev_double_i   (dec_double),
        .mem_req_o     (mem_req_o),
        .mem_addr_o    (mem_addr_o),
        .misr_op_o     (misr_op),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .halted_o      (halted_o),
        .sbc_o         (sbc_o),
        .err_o         (err_o),
        .evt_addr_o    (evt_addr_o)
    );

    aic_misr #(.W(DATA_W), .TAPS(32'h0040_0007)) u_misr (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_i   (misr_op),
        .data_i (dec_data),
        .sig_o  (sig_o)
    );

endmodule

// File: rtl/aic_checker.sv
module aic_checker #(
    parameter int AW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          abort_i,
    input logic          mem_req_o,
    input logic          busy_o,
    input logic          done_o,
    input logic          halted_o,
    input logic          sbc_o,
    input logic [AW-1:0] evt_addr_o,
    input logic [31:0]   sig_o
);

    p_req_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o);

    p_req_running_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (busy_o && !halted_o));

    p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (!busy_o && !done_o));

    p_sig_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(sig_o));

    p_evt_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(evt_addr_o));

    p_busy_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    p_sbc_from_sweep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sbc_o) |-> $past(busy_o));

endmodule

bind array_integrity_checker aic_checker #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .abort_i    (abort_i),
    .mem_req_o  (mem_req_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .halted_o   (halted_o),
    .sbc_o      (sbc_o),
    .evt_addr_o (evt_addr_o),
    .sig_o      (sig_o)
);

// File: tb/array_integrity_checker_tb.sv
`timescale 1ns/1ps
module array_integrity_checker_tb;

    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;

    typedef struct {
        logic [31:0]   sig;
        logic          sbc;
        logic          err;
        logic [AW-1:0] evt;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0, abort_i = 1'b0;
    logic [AW-1:0] lo_addr_i = '0, hi_addr_i = '0;
    logic          halt_on_sbc_i = 1'b0, halt_on_err_i = 1'b0, capture_en_i = 1'b0;
    logic          clr_sbc_i = 1'b0, clr_err_i = 1'b0;
    logic          mem_req_o;
    logic [AW-1:0] mem_addr_o;
    logic [38:0]   mem_rdata_i = '0;
    logic          busy_o, done_o, halted_o, sbc_o, err_o;
    logic [AW-1:0] evt_addr_o;
    logic [31:0]   sig_o;

    logic [38:0] mem  [DEPTH];
    logic [31:0] gold [DEPTH];
    int          kind [DEPTH];

    exp_t q[$];
    int   n_chk = 0, n_bad = 0;
    int   rd_bad = 0, rd_cnt = 0;
    int   exp_rd = 0;
    logic done_prev = 1'b0;

    always #2.5 clk = ~clk;

    array_integrity_checker #(.AW(AW)) u_dut (.*);

    always @(posedge clk) if (mem_req_o) mem_rdata_i <= mem[mem_addr_o];

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    function automatic logic [38:0] enc(input logic [31:0] d);
        logic [38:0] cw;
        logic [5:0]  s;
        int k;
        cw = '0; k = 0; s = '0;
        for (int p = 1; p <= 38; p++) begin
            if ((p & (p - 1)) != 0) begin
                cw[p] = d[k];
                k++;
            end
        end
        for (int p = 1; p <= 38; p++) if (cw[p]) s = s ^ 6'(p);
        for (int j = 0; j < 6; j++) cw[1 << j] = s[j];
        cw[0] = ^cw[38:1];
        return cw;
    endfunction

    function automatic logic [31:0] step(input logic [31:0] s, input logic [31:0] d);
        return ({s[30:0], 1'b0} ^ (s[31] ? 32'h0040_0007 : 32'h0)) ^ d;
    endfunction

    function automatic logic [31:0] model_sig(input int lo, input int hi);
        logic [31:0] s;
        s = '1;
        for (int a = lo; a <= hi; a++) s = step(s, (kind[a] == 2) ? (gold[a] ^ 32'h3) : gold[a]);
        return s;
    endfunction

    // Monitor: read order and scoreboard pop on each finished sweep.
    always @(negedge clk) begin
        if (mem_req_o) begin
            rd_cnt++;
            if (int'(mem_addr_o) != exp_rd) rd_bad++;
            exp_rd++;
        end
        if (done_o && !done_prev) begin
            if (q.size() == 0) begin
                check(1'b0, "R10", "unexpected done", 32'h1, 32'h0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(sig_o == e.sig, "R2", {e.tag, " signature"}, sig_o, e.sig);
                check(sbc_o == e.sbc, "R4", {e.tag, " sbc"}, 32'(sbc_o), 32'(e.sbc));
                check(err_o == e.err, "R5", {e.tag, " err"}, 32'(err_o), 32'(e.err));
                check(evt_addr_o == e.evt, "R6", {e.tag, " event address"}, 32'(evt_addr_o), 32'(e.evt));
                check(rd_bad == 0, "R1", {e.tag, " read order"}, 32'(rd_bad), 32'h0);
                check(!busy_o, "R10", {e.tag, " busy at done"}, 32'(busy_o), 32'h0);
            end
        end
        done_prev = done_o;
    end

    task automatic clean_all();
        for (int a = 0; a < 128; a++) begin
            mem[a]  = enc(gold[a]);
            kind[a] = 0;
        end
    endtask

    task automatic inject(input int a, input int k, input int bitpos);
        kind[a] = k;
        if (k == 1) mem[a] = enc(gold[a]) ^ (39'h1 << bitpos);
        else        mem[a] = enc(gold[a]) ^ 39'h28;
    endtask

    task automatic pulse_start(input int lo, input int hi, input logic hs, input logic he,
                               input logic cap);
        @(negedge clk);
        lo_addr_i = AW'(lo); hi_addr_i = AW'(hi);
        halt_on_sbc_i = hs; halt_on_err_i = he; capture_en_i = cap;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Driver: queue the expected result, then launch the sweep.
    task automatic sweep(input int lo, input int hi, input logic hs, input logic he,
                         input logic cap, input logic esbc, input logic eerr,
                         input int eevt, input string tag);
        exp_t e;
        e.sig = model_sig(lo, hi); e.sbc = esbc; e.err = eerr;
        e.evt = AW'(eevt); e.tag = tag;
        q.push_back(e);
        rd_bad = 0; exp_rd = lo;
        pulse_start(lo, hi, hs, he, cap);
    endtask

    task automatic wait_flag(input int which, input string req);
        int n;
        n = 0;
        while (((which == 0) ? !done_o : !halted_o) && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(n < 5000, req, "timeout waiting", 32'(n), 32'h0);
    endtask

    task automatic pulse_clr(input logic s, input logic e);
        @(negedge clk);
        clr_sbc_i = s; clr_err_i = e;
        @(negedge clk);
        clr_sbc_i = 1'b0; clr_err_i = 1'b0;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 32'h0, 32'h1);
        summary();
    end

    initial begin
        int snap;
        logic [31:0] sig_snap;
        for (int a = 0; a < DEPTH; a++) begin
            gold[a] = (32'(a) * 32'h9E37_79B1) ^ (32'(a) << 7);
            mem[a]  = enc(gold[a]);
            kind[a] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && !halted_o, "R1", "idle after reset",
              {29'b0, busy_o, done_o, halted_o}, 32'h0);
        check(!sbc_o && !err_o, "R1", "flags after reset", {30'b0, sbc_o, err_o}, 32'h0);

        // R1/R2: clean sweep
        sweep(0, 15, 0, 0, 0, 0, 0, 0, "R1 clean window");
        wait_flag(0, "R1");

        // R2: one word of zero gives a known constant
        gold[40] = 32'h0; mem[40] = enc(32'h0);
        sweep(40, 40, 0, 0, 0, 0, 0, 0, "R2 single word");
        wait_flag(0, "R2");
        @(negedge clk);
        check(sig_o == 32'hFFBF_FFF9, "R2", "zero word constant", sig_o, 32'hFFBF_FFF9);

        // R3/R4/R6: single-bit error, capture disabled
        inject(5, 1, 6);
        sweep(0, 15, 0, 0, 0, 1, 0, 0, "R3 corrected no capture");
        wait_flag(0, "R3");

        // R3/R6: parity-bit flip plus data flip, capture enabled
        inject(11, 1, 0);
        sweep(0, 15, 0, 0, 1, 1, 0, 11, "R6 capture on");
        wait_flag(0, "R6");
        clean_all();

        // R5: double-bit folds raw data
        inject(7, 2, 0);
        sweep(0, 20, 0, 0, 1, 0, 1, 7, "R5 double-bit");
        wait_flag(0, "R5");
        clean_all();

        // R7/R9: break on corrected word
        inject(3, 1, 9);
        sweep(0, 10, 1, 0, 1, 0, 0, 3, "R7 break sbc");
        wait_flag(1, "R7");
        check(sbc_o && evt_addr_o == 3, "R7", "halt state", {31'b0, sbc_o}, 32'h1);
        snap = rd_cnt;
        repeat (6) @(negedge clk);
        check(rd_cnt == snap, "R7", "no reads while halted", 32'(rd_cnt - snap), 32'h0);
        pulse_clr(1'b0, 1'b1);
        repeat (3) @(negedge clk);
        check(halted_o, "R9", "other flag clear keeps halt", 32'(halted_o), 32'h1);
        pulse_clr(1'b1, 1'b0);
        wait_flag(0, "R9");
        clean_all();

        // R8/R9: break on double-bit only, corrected word earlier
        inject(2, 1, 20);
        inject(9, 2, 0);
        sweep(0, 12, 0, 1, 1, 0, 0, 9, "R8 break err");
        wait_flag(1, "R8");
        check(err_o && sbc_o, "R8", "both flags at halt", {30'b0, sbc_o, err_o}, 32'h3);
        check(evt_addr_o == 9, "R8", "halt address", 32'(evt_addr_o), 32'd9);
        pulse_clr(1'b1, 1'b0);
        repeat (3) @(negedge clk);
        check(halted_o && !sbc_o, "R9", "sbc clear keeps err halt", 32'(halted_o), 32'h1);
        pulse_clr(1'b0, 1'b1);
        wait_flag(0, "R9");
        clean_all();

        // R12: start while busy ignored
        sweep(0, 30, 0, 0, 0, 0, 0, 0, "R12 start while busy");
        repeat (10) @(negedge clk);
        @(negedge clk);
        lo_addr_i = AW'(50); hi_addr_i = AW'(51); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_flag(0, "R12");

        // R11: abort mid-sweep keeps partial signature
        rd_bad = 0; exp_rd = 0;
        pulse_start(0, 100, 0, 0, 0);
        repeat (20) @(negedge clk);
        abort_i = 1'b1;
        @(negedge clk);
        abort_i = 1'b0;
        check(!busy_o && !done_o, "R11", "idle after abort", {30'b0, busy_o, done_o}, 32'h0);
        sig_snap = sig_o;
        check(sig_o != 32'hFFFF_FFFF, "R11", "partial signature kept", sig_o, 32'h0);
        repeat (10) @(negedge clk);
        check(sig_o == sig_snap, "R11", "signature stable after abort", sig_o, sig_snap);
        check(q.size() == 0, "R10", "scoreboard drained", 32'(q.size()), 32'h0);

        summary();
    end

endmodule